// File: doc/BRIEF.md
# Paired-Output FIR Filter Engine

This block is a direct-form FIR filter that produces two consecutive output samples from a single pass over its tap weights. Two multiply-accumulate lanes run side by side. In every step both lanes use the same weight. Lane 0 multiplies it by the sample being read in that step. Lane 1 multiplies it by the sample read one step earlier, which a one-deep delay register holds. A filter of NTAPS taps therefore needs NTAPS weight reads and NTAPS+1 sample reads for each pair of outputs.

Samples are written one at a time into a circular history buffer. Weights are written by tap index into a small weight store before the first run. The host writes two new samples and then pulses `start`. After a fixed number of cycles, `done` pulses and the two rounded, clamped results appear on the output pair. The outputs keep those values until the next run finishes.

Top module: `dual_mac_fir`

## Requirements
- R1: While reset is applied, and in the cycles after it is released, `done` is 0 and both outputs are 0.
- R2: Let s(0) be the most recently written sample and s(1) the one written before it. `y_odd` is the sum over i of w(i)·s(i), and `y_even` is the sum over i of w(i)·s(i+1), for i = 0..NTAPS-1. All values are two's complement 16-bit. Each result is formed as (sum + 2^14) arithmetically shifted right by 15.
- R3: `done` goes high on the (NTAPS+3)-th rising edge after the edge that samples `start`. It stays high for exactly one cycle.
- R4: A `start` pulse that arrives while a run is in progress is ignored. No second `done` pulse follows it, and the results of the current run are unchanged.
- R5: A shifted result above 32767 is output as 32767 (0x7FFF). A shifted result below -32768 is output as -32768 (0x8000).
- R6: Every sample write advances the history write position by one and wraps around. After any number of writes, a run uses only the latest NTAPS+1 samples.
- R7: Between `done` pulses, `y_even` and `y_odd` hold their values, even when samples or weights are written.
- R8: A weight written at `cof_addr` = i multiplies the sample at history distance i (lane 1) and at distance i+1 (lane 0).
- R9: The sum is kept at 40 bits. A partial sum beyond the 32-bit range that later returns into range gives the exact result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_we | input | 1 | Write one sample into the history buffer |
| smp_din | input | 16 | Sample value, signed |
| cof_we | input | 1 | Write one tap weight |
| cof_addr | input | $clog2(NTAPS) | Tap index of the weight being written |
| cof_din | input | 16 | Weight value, signed Q1.15 |
| start | input | 1 | Begin computing an output pair |
| done | output | 1 | One-cycle pulse when both outputs are updated |
| y_even | output | 16 | Older output of the pair (uses s(1)..s(NTAPS)) |
| y_odd | output | 16 | Newer output of the pair (uses s(0)..s(NTAPS-1)) |

## Verification
The checker counts cycles from each accepted `start`. It assumes that no sample or weight write happens while a run is in progress, because such a write would change operands in the middle of a pass. The bench writes the samples and weights only between runs, and it waits for `done` before the next write. The only stimulus it applies during a run is the stray `start` pulse that checks the ignore behaviour. The bench also writes at least NTAPS+1 samples before the first run, so every history slot the engine reads holds a known value.

// File: rtl/fir2_pkg.sv
`timescale 1ns/1ps
package fir2_pkg;
  localparam int LANES = 2;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN, ST_OUT} fsm_t;
endpackage

// File: rtl/fir2_ctrl.sv
`timescale 1ns/1ps
module fir2_ctrl
  import fir2_pkg::*;
#(
  parameter int NTAPS = 8,
  parameter int KW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          clr,
  output logic          cap,
  output logic          acc_en,
  output logic          out_ld,
  output logic [KW-1:0] k
);
  localparam logic [KW-1:0] KLAST = KW'(NTAPS);

  fsm_t          st_q, st_d;
  logic [KW-1:0] k_q, k_d;
  logic          v_q, v_d;

  always_comb begin
    st_d = st_q;
    k_d  = k_q;
    v_d  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d = ST_RUN;
        k_d  = '0;
      end
      ST_RUN: begin
        k_d = k_q + KW'(1);
        v_d = (k_q != '0);
        if (k_q == KLAST) st_d = ST_DRAIN;
      end
      ST_DRAIN: st_d = ST_OUT;
      ST_OUT:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      k_q  <= '0;
      v_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      k_q  <= k_d;
      v_q  <= v_d;
    end
  end

  assign clr    = (st_q == ST_IDLE) && start;
  assign cap    = (st_q == ST_RUN);
  assign acc_en = v_q;
  assign out_ld = (st_q == ST_OUT);
  assign k      = k_q;
endmodule

// File: rtl/fir2_ring.sv
`timescale 1ns/1ps
module fir2_ring #(
  parameter int DW = 16,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] din,
  input  logic [PW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic [PW-1:0] wptr
);
  localparam int DEPTH = 1 << PW;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d;

  always_ff @(posedge clk) begin
    if (we) mem[wptr_q] <= din;
  end

  always_comb wptr_d = we ? wptr_q + PW'(1) : wptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wptr_q <= '0;
    else        wptr_q <= wptr_d;
  end

  assign rdata = mem[raddr];
  assign wptr  = wptr_q;
endmodule

// File: rtl/fir2_coef.sv
`timescale 1ns/1ps
module fir2_coef #(
  parameter int DW    = 16,
  parameter int NTAPS = 8,
  parameter int CAW   = 3
) (
  input  logic           clk,
  input  logic           we,
  input  logic [CAW-1:0] waddr,
  input  logic [DW-1:0]  din,
  input  logic [CAW-1:0] raddr,
  output logic [DW-1:0]  rdata
);
  localparam logic [CAW:0] NLIM = (CAW+1)'(NTAPS);

  logic [DW-1:0] mem [NTAPS];

  always_ff @(posedge clk) begin
    if (we && ({1'b0, waddr} < NLIM)) mem[waddr] <= din;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fir2_mac.sv
`timescale 1ns/1ps
module fir2_mac #(
  parameter int DW = 16,
  parameter int AW = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  output logic signed [AW-1:0] acc
);
  localparam int PWID = 2 * DW;

  logic signed [PWID-1:0] prod;
  logic signed [AW-1:0]   prod_x, acc_q, acc_d;

  always_comb begin
    prod   = a * b;
    prod_x = {{(AW-PWID){prod[PWID-1]}}, prod};
    if (clr)     acc_d = '0;
    else if (en) acc_d = acc_q + prod_x;
    else         acc_d = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;
endmodule

// File: rtl/dual_mac_fir.sv
`timescale 1ns/1ps
module dual_mac_fir
  import fir2_pkg::*;
#(
  parameter int NTAPS = 8,
  parameter int DW    = 16,
  parameter int AW    = 40,
  parameter int FRAC  = 15
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_we,
  input  logic [DW-1:0]            smp_din,
  input  logic                     cof_we,
  input  logic [$clog2(NTAPS)-1:0] cof_addr,
  input  logic [DW-1:0]            cof_din,
  input  logic                     start,
  output logic                     done,
  output logic [DW-1:0]            y_even,
  output logic [DW-1:0]            y_odd
);
  localparam int CAW = $clog2(NTAPS);
  localparam int PW  = $clog2(NTAPS + 1);
  localparam int KW  = PW;
  localparam logic signed [AW-1:0] BIAS = {{(AW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
  localparam logic signed [AW-1:0] YMAX = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] YMIN = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rs_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  logic          clr, cap, acc_en, out_ld;
  logic [KW-1:0] k;
  logic [PW-1:0] wr_ptr, base_q, base_d, rd_addr;
  logic [DW-1:0] smp_rd, cof_rd;

  fir2_ctrl #(.NTAPS(NTAPS), .KW(KW)) u_ctrl (
    .clk(clk), .rst_n(rst_sn), .start(start), .clr(clr), .cap(cap),
    .acc_en(acc_en), .out_ld(out_ld), .k(k)
  );

  fir2_ring #(.DW(DW), .PW(PW)) u_ring (
    .clk(clk), .rst_n(rst_sn), .we(smp_we), .din(smp_din),
    .raddr(rd_addr), .rdata(smp_rd), .wptr(wr_ptr)
  );

  fir2_coef #(.DW(DW), .NTAPS(NTAPS), .CAW(CAW)) u_coef (
    .clk(clk), .we(cof_we), .waddr(cof_addr), .din(cof_din),
    .raddr(CAW'(k - KW'(1))), .rdata(cof_rd)
  );

  // newest sample is at wr_ptr-1; step k reads distance k back
  assign rd_addr = base_q - PW'(1) - PW'(k);

  // operand stage: current sample, previous sample, shared weight
  logic signed [DW-1:0] xr_q, xr_d, dly_q, dly_d, cr_q, cr_d;
  always_comb begin
    base_d = clr ? wr_ptr : base_q;
    xr_d   = cap ? smp_rd : xr_q;
    dly_d  = cap ? xr_q   : dly_q;
    cr_d   = cap ? cof_rd : cr_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      base_q <= '0;
      xr_q   <= '0;
      dly_q  <= '0;
      cr_q   <= '0;
    end else begin
      base_q <= base_d;
      xr_q   <= xr_d;
      dly_q  <= dly_d;
      cr_q   <= cr_d;
    end
  end

  logic signed [DW-1:0] opnd [LANES];
  logic        [DW-1:0] y_q  [LANES];
  assign opnd[0] = xr_q;
  assign opnd[1] = dly_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [AW-1:0] acc, biased, shr;
    logic        [DW-1:0] y_d;

    fir2_mac #(.DW(DW), .AW(AW)) u_mac (
      .clk(clk), .rst_n(rst_sn), .clr(clr), .en(acc_en),
      .a(cr_q), .b(opnd[l]), .acc(acc)
    );

    always_comb begin
      biased = acc + BIAS;
      shr    = biased >>> FRAC;
      if (!out_ld)          y_d = y_q[l];
      else if (shr > YMAX)  y_d = {1'b0, {(DW-1){1'b1}}};
      else if (shr < YMIN)  y_d = {1'b1, {(DW-1){1'b0}}};
      else                  y_d = shr[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn) y_q[l] <= '0;
      else         y_q[l] <= y_d;
    end
  end

  logic done_q;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) done_q <= 1'b0;
    else         done_q <= out_ld;
  end

  assign done   = done_q;
  assign y_even = y_q[0];
  assign y_odd  = y_q[1];
endmodule

// File: rtl/dual_mac_fir_chk.sv
`timescale 1ns/1ps
module dual_mac_fir_chk #(
  parameter int NTAPS = 8,
  parameter int DW    = 16,
  parameter int PW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          done,
  input logic          smp_we,
  input logic [DW-1:0] y_even,
  input logic [DW-1:0] y_odd,
  input logic [PW-1:0] wptr
);
  localparam int LAT = NTAPS + 3;
  localparam int CW  = $clog2(LAT + 2) + 1;
  localparam logic [CW-1:0] LATC = CW'(LAT);

  logic          ck_busy, past_ok;
  logic [CW-1:0] ck_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_busy <= 1'b0;
      ck_cnt  <= '0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (start && (!ck_busy || done)) begin
        ck_busy <= 1'b1;
        ck_cnt  <= '0;
      end else if (ck_busy) begin
        if (ck_cnt <= LATC) ck_cnt <= ck_cnt + CW'(1);
        if (done) ck_busy <= 1'b0;
      end
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3 R4
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ck_busy && ck_cnt == LATC));

  // R3
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ck_busy |-> ck_cnt <= LATC);

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !done) |-> ($stable(y_even) && $stable(y_odd)));

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(smp_we)) |-> (wptr == PW'($past(wptr) + PW'(1))));

  // R6
  ptr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(smp_we)) |-> $stable(wptr));
endmodule

bind dual_mac_fir dual_mac_fir_chk #(.NTAPS(NTAPS), .DW(DW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_sn), .start(start), .done(done), .smp_we(smp_we),
  .y_even(y_even), .y_odd(y_odd), .wptr(wr_ptr)
);

// File: tb/dual_mac_fir_tb.sv
`timescale 1ns/1ps
module dual_mac_fir_tb;
  localparam int NTAPS = 8;
  localparam int DW    = 16;
  localparam int CAW   = $clog2(NTAPS);

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic smp_we = 1'b0, cof_we = 1'b0, start = 1'b0;
  logic [DW-1:0]  smp_din = '0, cof_din = '0;
  logic [CAW-1:0] cof_addr = '0;
  logic done;
  logic [DW-1:0] y_even, y_odd;

  int n_chk = 0;
  int n_bad = 0;
  int win  [NTAPS+1];
  int wgt  [NTAPS];

  always #2 clk = ~clk;

  dual_mac_fir #(.NTAPS(NTAPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_we(smp_we), .smp_din(smp_din),
    .cof_we(cof_we), .cof_addr(cof_addr), .cof_din(cof_din),
    .start(start), .done(done), .y_even(y_even), .y_odd(y_odd)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rsat(input longint a);
    longint r = (a + 64'sd16384) >>> 15;
    if (r > 32767)  return 32767;
    if (r < -32768) return -32768;
    return int'(r);
  endfunction

  task automatic model(output int e_even, output int e_odd);
    longint s0 = 0, s1 = 0;
    for (int i = 0; i < NTAPS; i++) begin
      s1 += longint'(wgt[i]) * longint'(win[i]);
      s0 += longint'(wgt[i]) * longint'(win[i+1]);
    end
    e_even = rsat(s0);
    e_odd  = rsat(s1);
  endtask

  task automatic push(input int x);
    for (int i = NTAPS; i > 0; i--) win[i] = win[i-1];
    win[0] = x;
    @(negedge clk);
    smp_we = 1'b1; smp_din = DW'(x);
    @(negedge clk);
    smp_we = 1'b0;
  endtask

  task automatic put_wgt(input int i, input int c);
    wgt[i] = c;
    @(negedge clk);
    cof_we = 1'b1; cof_addr = CAW'(i); cof_din = DW'(c);
    @(negedge clk);
    cof_we = 1'b0;
  endtask

  task automatic run_pair(input string req, input bit poke);
    int cnt, e0, e1, extra;
    model(e0, e1);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cnt = 0;
    while (!done && cnt < 4*NTAPS) begin
      @(negedge clk);
      cnt++;
      if (poke && cnt == 2) start = 1'b1;
      if (poke && cnt == 3) start = 1'b0;
    end
    chk("R3 latency", cnt, NTAPS + 3);
    chk({req, " y_even"}, int'($signed(y_even)), e0);
    chk({req, " y_odd"},  int'($signed(y_odd)),  e1);
    @(negedge clk);
    chk("R3 one-cycle done", int'(done), 0);
    if (poke) begin
      extra = 0;
      repeat (2*NTAPS) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk("R4 no second done", extra, 0);
    end
  endtask

  task automatic fill(input int x);
    for (int i = 0; i <= NTAPS; i++) push(x);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 y_even after reset", int'(y_even), 0);
    chk("R1 y_odd after reset", int'(y_odd), 0);
  endtask

  task automatic t_impulse;
    for (int i = 0; i < NTAPS; i++) put_wgt(i, (i + 1) * 1111);
    foreach (win[j]) win[j] = 0;
    for (int d = 0; d <= NTAPS; d += 4) begin
      fill(0);
      push(16384);
      for (int z = 0; z < d; z++) push(0);
      run_pair("R8 impulse", 1'b0);
    end
  endtask

  task automatic t_random;
    for (int i = 0; i < NTAPS; i++) put_wgt(i, int'($signed(16'($urandom_range(0, 16383)))) - 8192);
    for (int r = 0; r < 6; r++) begin
      push(int'($signed(16'($urandom))));
      push(int'($signed(16'($urandom))));
      run_pair("R2 R6 random", 1'b0);
    end
  endtask

  task automatic t_sat;
    for (int i = 0; i < NTAPS; i++) put_wgt(i, 32767);
    fill(32767);
    run_pair("R5 clamp high", 1'b0);
    fill(-32768);
    run_pair("R5 clamp low", 1'b0);
  endtask

  task automatic t_wide;
    for (int i = 0; i < NTAPS; i++) put_wgt(i, (i < NTAPS/2) ? -32768 : 32767);
    fill(-32768);
    run_pair("R9 wide sum", 1'b0);
  endtask

  task automatic t_busy;
    for (int i = 0; i < NTAPS; i++) put_wgt(i, 4096 - i * 700);
    push(1234); push(-2222);
    run_pair("R4 stray start", 1'b1);
  endtask

  task automatic t_hold;
    int h0, h1;
    h0 = int'(y_even); h1 = int'(y_odd);
    push(999); push(-999);
    put_wgt(0, 77);
    repeat (5) @(negedge clk);
    chk("R7 y_even held", int'(y_even), h0);
    chk("R7 y_odd held", int'(y_odd), h1);
    chk("R7 no done", int'(done), 0);
    run_pair("R2 after hold", 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_impulse();
    t_random();
    t_sat();
    t_wide();
    t_busy();
    t_hold();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule